// File: doc/BRIEF.md
# MDIO Command-Word Management Engine

This block runs one complete clause-22 management transaction on an MDC/MDIO pair for each 32-bit command word written to it. The command word carries the opcode, the PHY address, the register address and, for a write, the 16-bit payload. The engine generates MDC from the system clock, shifts the frame out, and for a read releases the data line and collects 16 bits from the PHY. When the frame is over it raises a completion flag in the readback word; after a read, the low half of that word holds the returned value.

Two serial input pins are provided, one wired to an on-board transceiver and one to an external one. The PHY address of the command picks which pin is sampled. An address matching neither returns zero.

The controller is a single state machine with states `S_IDLE`, `S_PRE`, `S_START`, `S_OP`, `S_PHY`, `S_REG`, `S_TA` and `S_DATA`. Its transitions are: `S_IDLE` to `S_PRE` when a command is accepted; each field state to the next on the MDC falling edge that ends its last bit, in the order `S_PRE`, `S_START`, `S_OP`, `S_PHY`, `S_REG`, `S_TA`, `S_DATA`; and `S_DATA` to `S_IDLE` (with completion) after the sixteenth data bit.

Top module: `mdio_frame_engine`

## Requirements
- R1: A command written while idle is decoded as follows: bits 29:28 are the opcode (2'b10 means read, any other value means write), bits 27:23 are the PHY address, bits 22:18 are the register address, and bits 15:0 are the write data.
- R2: Every frame begins with PRE_BITS (default 32) one-bits driven on `mdio_out`, with `mdio_oe` high.
- R3: The preamble is followed by the start pattern 0,1 and then the opcode bits: 0,1 for a write and 1,0 for a read.
- R4: The PHY address and the register address follow the opcode, 5 bits each, MSB first. A write then sends turnaround 1,0 and the 16 data bits MSB first. Every frame lasts exactly 64 MDC periods.
- R5: On a read, `mdio_oe` is low for both turnaround bits and all 16 data bits. The 16 bits are sampled on MDC rising edges, MSB first.
- R6: A read samples `mdio_in_int` when the PHY address equals INT_PHY_ADDR (default 0) and `mdio_in_ext` when it equals EXT_PHY_ADDR (default 1). Any other address returns 16'h0000.
- R7: Readback bit 16 (done) clears on the cycle after a command is accepted. It sets when the frame ends. After a read, readback bits 15:0 then hold the received data, and bits 31:17 echo the command.
- R8: A command write while a frame is in progress is ignored: the readback word's command field, the frame on the wire and the frame length are unchanged.
- R9: MDC is low while idle and has a period of 2*HALF_DIV system clocks during a frame. `mdio_out` changes only while MDC is low.
- R10: After reset, done is 0, MDC is 0 and `mdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 32 | Command word |
| cmd_rdata | output | 32 | Readback: command echo in 31:17, done in 16, data in 15:0 |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the data line |
| mdio_in_int | input | 1 | Serial data from the internal transceiver |
| mdio_in_ext | input | 1 | Serial data from the external transceiver |

## Verification
The bench captures every MDC rising edge and compares each whole frame, including the output-enable pattern, against a frame built from the requirements. This catches a wrong field order or bit order, a wrong opcode, and a preamble of the wrong length. Reads go to the internal address, the external address and an unmatched address, with different patterns on the two input pins; a wrong pin selection, or data that is not zero for an unmatched address, shows up as a wrong readback value. The bench also writes a second command in the middle of a frame: a design that restarts or re-latches would show more than 64 MDC periods or a changed command echo. It checks that done clears right after acceptance, and it measures MDC periods, which exposes an off-by-one divider.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    // Command word field positions
    localparam int OP_HI   = 29;
    localparam int PHY_HI  = 27;
    localparam int REG_HI  = 22;
    localparam int DONE_BIT = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_START,
        S_OP,
        S_PHY,
        S_REG,
        S_TA,
        S_DATA
    } mdio_state_e;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] TERM = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;
    logic          term;

    assign term      = run && (cnt == TERM);
    assign rise_tick = term && !mdc;
    assign fall_tick = term && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (term) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_rx_select.sv
module mdio_rx_select #(
    parameter int           AW       = 5,
    parameter logic [AW-1:0] INT_ADDR = '0,
    parameter logic [AW-1:0] EXT_ADDR = AW'(1)
) (
    input  logic [AW-1:0] phy_addr,
    input  logic          in_int,
    input  logic          in_ext,
    output logic          rx_bit
);
    always_comb begin
        if (phy_addr == INT_ADDR)
            rx_bit = in_int;
        else if (phy_addr == EXT_ADDR)
            rx_bit = in_ext;
        else
            rx_bit = 1'b0;
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int         HALF_DIV     = 2,
    parameter int         PRE_BITS     = 32,
    parameter logic [4:0] INT_PHY_ADDR = 5'd0,
    parameter logic [4:0] EXT_PHY_ADDR = 5'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in_int,
    input  logic        mdio_in_ext
);
    localparam int CNT_W = ($clog2(PRE_BITS) > 4) ? $clog2(PRE_BITS) : 4;

    mdio_state_e      state, state_n;
    logic [CNT_W-1:0] bit_cnt, bit_cnt_n;
    logic [CNT_W-1:0] last_idx;
    logic [31:17]     cmd_q;
    logic [DATA_W-1:0] data_q;
    logic             done_q;
    logic             busy, accept, is_read;
    logic             rise_tick, fall_tick, rx_bit;
    logic [ADDR_W-1:0] phy_addr, reg_addr;

    assign busy     = (state != S_IDLE);
    assign accept   = !busy && cmd_wr;
    assign is_read  = (cmd_q[OP_HI -: 2] == 2'b10);
    assign phy_addr = cmd_q[PHY_HI -: ADDR_W];
    assign reg_addr = cmd_q[REG_HI -: ADDR_W];
    assign cmd_rdata = {cmd_q, done_q, data_q};

    mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_rx_select #(
        .AW       (ADDR_W),
        .INT_ADDR (INT_PHY_ADDR),
        .EXT_ADDR (EXT_PHY_ADDR)
    ) u_rxsel (
        .phy_addr (phy_addr),
        .in_int   (mdio_in_int),
        .in_ext   (mdio_in_ext),
        .rx_bit   (rx_bit)
    );

    // Last bit index of the current field
    always_comb begin
        unique case (state)
            S_PRE:   last_idx = CNT_W'(PRE_BITS - 1);
            S_PHY,
            S_REG:   last_idx = CNT_W'(ADDR_W - 1);
            S_DATA:  last_idx = CNT_W'(DATA_W - 1);
            default: last_idx = CNT_W'(1);
        endcase
    end

    // Next state
    always_comb begin
        state_n   = state;
        bit_cnt_n = bit_cnt;
        if (state == S_IDLE) begin
            if (cmd_wr) begin
                state_n   = S_PRE;
                bit_cnt_n = '0;
            end
        end else if (fall_tick) begin
            if (bit_cnt == last_idx) begin
                bit_cnt_n = '0;
                unique case (state)
                    S_PRE:   state_n = S_START;
                    S_START: state_n = S_OP;
                    S_OP:    state_n = S_PHY;
                    S_PHY:   state_n = S_REG;
                    S_REG:   state_n = S_TA;
                    S_TA:    state_n = S_DATA;
                    default: state_n = S_IDLE;
                endcase
            end else begin
                bit_cnt_n = bit_cnt + 1'b1;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            bit_cnt <= '0;
        end else begin
            state   <= state_n;
            bit_cnt <= bit_cnt_n;
        end
    end

    // Command, data and completion registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            data_q <= '0;
            done_q <= 1'b0;
        end else begin
            if (accept) begin
                cmd_q  <= cmd_wdata[31:17];
                data_q <= cmd_wdata[DATA_W-1:0];
                done_q <= 1'b0;
            end else if (state == S_DATA && is_read && rise_tick) begin
                data_q <= {data_q[DATA_W-2:0], rx_bit};
            end
            if (state == S_DATA && fall_tick && bit_cnt == CNT_W'(DATA_W - 1))
                done_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        mdio_oe  = busy && !(is_read && (state == S_TA || state == S_DATA));
        mdio_out = 1'b0;
        unique case (state)
            S_IDLE:  mdio_out = 1'b0;
            S_PRE:   mdio_out = 1'b1;
            S_START: mdio_out = (bit_cnt != '0);
            S_OP:    mdio_out = is_read ? (bit_cnt == '0) : (bit_cnt != '0);
            S_PHY:   mdio_out = phy_addr[ADDR_W - 1 - int'(bit_cnt)];
            S_REG:   mdio_out = reg_addr[ADDR_W - 1 - int'(bit_cnt)];
            S_TA:    mdio_out = !is_read && (bit_cnt == '0);
            S_DATA:  mdio_out = !is_read && data_q[DATA_W - 1 - int'(bit_cnt)];
            default: mdio_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/mdio_frame_chk.sv
module mdio_frame_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe,
    input logic [31:0] cmd_rdata
);
    // R9
    out_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_out) |-> !mdc);

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rdata[16] |-> (!mdio_oe && !mdc));

    // R7
    done_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_rdata[16]) |-> !busy);

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> $stable(cmd_rdata[31:17]));

    // R5
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe) |-> (cmd_rdata[29:28] == 2'b10 || cmd_rdata[16]));

    // R9
    idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !mdc);
endmodule

bind mdio_frame_engine mdio_frame_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .busy      (busy),
    .mdc       (mdc),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .cmd_rdata (cmd_rdata)
);

// File: tb/tb_mdio_frame_engine.sv
`timescale 1ns/1ps
module tb_mdio_frame_engine;
    localparam int HALF_DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in_int = 1'b0;
    logic        mdio_in_ext = 1'b0;

    int errors = 0;
    int checks = 0;

    logic [63:0] cap, oecap;
    int          rises;
    realtime     last_rise, per_min, per_max;
    logic [15:0] int_val = 16'hA5C3;
    logic [15:0] ext_val = 16'h3C96;

    always #2.5 clk = !clk;

    mdio_frame_engine #(.HALF_DIV(HALF_DIV)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .cmd_wdata   (cmd_wdata),
        .cmd_rdata   (cmd_rdata),
        .mdc         (mdc),
        .mdio_out    (mdio_out),
        .mdio_oe     (mdio_oe),
        .mdio_in_int (mdio_in_int),
        .mdio_in_ext (mdio_in_ext)
    );

    // Bus monitor
    always @(posedge mdc) begin
        cap   = {cap[62:0], mdio_oe ? mdio_out : 1'b0};
        oecap = {oecap[62:0], mdio_oe};
        if (rises > 0) begin
            if ($realtime - last_rise < per_min) per_min = $realtime - last_rise;
            if ($realtime - last_rise > per_max) per_max = $realtime - last_rise;
        end
        last_rise = $realtime;
        rises++;
    end

    // PHY responder: drives data on falling MDC during the data phase
    always @(negedge mdc) begin
        if (rises >= 48 && rises <= 63) begin
            mdio_in_int <= int_val[63 - rises];
            mdio_in_ext <= ext_val[63 - rises];
        end else begin
            mdio_in_int <= 1'b0;
            mdio_in_ext <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cmd(input logic [1:0] op, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] d);
        return {2'b00, op, phy, rg, 2'b00, d};
    endfunction

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
                (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : d)};
    endfunction

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        rises = 0; per_min = 1.0e9; per_max = 0.0;
        cmd_wr = 1'b1; cmd_wdata = w;
        @(negedge clk);
        cmd_wr = 1'b0;
        // R7: done cleared right after acceptance
        chk(cmd_rdata[16] == 1'b0, "R7 done clear on accept", {63'd0, cmd_rdata[16]}, 64'd0);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (cmd_rdata[16]) return;
        end
        chk(1'b0, "R7 done timeout", 64'd0, 64'd1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cmd_rdata[16] == 1'b0 && mdc == 1'b0 && mdio_oe == 1'b0, "R10 reset state",
            {61'd0, cmd_rdata[16], mdc, mdio_oe}, 64'd0);
    endtask

    task automatic t_write(input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] d);
        issue(mk_cmd(op, phy, rg, d));
        wait_done();
        chk(rises == 64, "R4 frame length", 64'(rises), 64'd64);
        chk(cap == exp_frame(0, phy, rg, d), "R2 R3 R4 write frame", cap, exp_frame(0, phy, rg, d));
        chk(oecap == '1, "R2 write oe pattern", oecap, '1);
        chk(cmd_rdata[31:17] == mk_cmd(op, phy, rg, d) >> 17, "R1 command echo",
            64'(cmd_rdata[31:17]), 64'(mk_cmd(op, phy, rg, d) >> 17));
        chk(per_min == 2.0 * HALF_DIV * 5.0 && per_max == 2.0 * HALF_DIV * 5.0, "R9 mdc period",
            64'(int'(per_max)), 64'(2 * HALF_DIV * 5));
    endtask

    task automatic t_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] expd);
        issue(mk_cmd(2'b10, phy, rg, 16'hFFFF));
        wait_done();
        chk(cap == exp_frame(1, phy, rg, 0), "R3 R4 read header", cap, exp_frame(1, phy, rg, 0));
        chk(oecap == {46'h3FFF_FFFF_FFFF, 18'h0}, "R5 read release",
            oecap, {46'h3FFF_FFFF_FFFF, 18'h0});
        chk(cmd_rdata[15:0] == expd, "R6 R7 read data", 64'(cmd_rdata[15:0]), 64'(expd));
    endtask

    task automatic t_busy_ignore();
        logic [31:0] first;
        first = mk_cmd(2'b01, 5'd1, 5'd9, 16'h1234);
        issue(first);
        repeat (40) @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = mk_cmd(2'b10, 5'd0, 5'd3, 16'h0000);
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(cmd_rdata[31:17] == first[31:17], "R8 echo unchanged",
            64'(cmd_rdata[31:17]), 64'(first[31:17]));
        wait_done();
        chk(rises == 64, "R8 no restart", 64'(rises), 64'd64);
        chk(cap == exp_frame(0, 5'd1, 5'd9, 16'h1234), "R8 frame intact",
            cap, exp_frame(0, 5'd1, 5'd9, 16'h1234));
    endtask

    task automatic t_idle_quiet();
        repeat (12) @(negedge clk);
        chk(mdc == 1'b0 && mdio_oe == 1'b0 && rises == 64, "R9 idle mdc low",
            {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rises = 0; cap = '0; oecap = '0; last_rise = 0.0; per_min = 1.0e9; per_max = 0.0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write(2'b01, 5'd3, 5'd17, 16'hBEEF);
        t_write(2'b00, 5'd31, 5'd0, 16'h0001);   // R1: opcode 00 treated as write
        t_idle_quiet();
        t_read(5'd0, 5'd2, 16'hA5C3);            // internal pin
        t_read(5'd1, 5'd30, 16'h3C96);           // external pin
        t_read(5'd7, 5'd5, 16'h0000);            // unmatched address
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule